// File: doc/BRIEF.md
# UART Register Handshake Front End

This block is the register-facing side of a small serial port. It sits on a 32-bit read/write bus and holds three word registers: a data word, a control word and a rate word. Software sends and receives through flag bits that share the data word with the byte itself, so it needs no separate status register. It polls the transmit-ready flag and then writes a byte with that flag set to queue it. It polls the receive-valid flag, reads the byte, and writes that flag back as 1 to consume the byte.

Behind the registers there is one holding slot per direction. The transmit slot feeds a shift engine that sends 8N1 frames: the line idles high, then one low start bit, eight data bits least significant first, and one high stop bit. The receive side synchronises the line, samples each bit near its centre and hands each complete frame to the receive slot. A fractional rate generator supplies the oversampling tick: a prescaler counts `scale+1` clock cycles, and at each of its strobes a 16-bit `step` is added to a 16-bit accumulator. Each carry out is one tick, and one bit lasts 16 ticks.

Top module: `serreg_top`

## Requirements
- R1: After reset the data word reads 0x0000_0200 (transmit-ready 1, receive-valid 0, byte 0), the control and rate words read 0 and `txd` is high.
- R2: A data-word write with bit 9 set while bit 9 reads 1 transmits bits 7:0 on `txd` as one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts 16 rate ticks, and the line is high whenever no frame is in progress.
- R3: While a queued byte waits behind a frame in progress, bit 9 reads 0, and a data-word write with bit 9 set is ignored: no extra frame is sent.
- R4: After a received frame with a high stop bit, data-word bit 8 reads 1 and bits 7:0 hold the received byte.
- R5: A data-word write with bit 8 set clears receive-valid. A data-word write with bits 9 and 8 both clear changes neither flag, the received byte or the line.
- R6: A data-word write with both bits 9 and 8 set queues the byte for transmission and also consumes the received byte.
- R7: If a frame completes while receive-valid is 1 and no consume happens in that cycle, the held byte is kept, the new byte is lost, and control bit 12 becomes 1 and stays 1 until a control write with bit 12 set clears it.
- R8: The control word keeps bits 3:2 (interface mode), bit 7 (transmit-ready override) and bit 8 (receive-ready override) as written. Its other writable bits read 0.
- R9: The rate word keeps the step in bits 15:0 and the prescale in bits 27:16. With scale S and step T, the tick rate is clk*T/((S+1)*65536), so S=1, T=0x8000 gives 64 clock cycles per bit and S=0, T=0x8000 gives 32.
- R10: A received frame whose stop bit is low is discarded: receive-valid stays 0.
- R11: The unused word offset 0x0C reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, qualified by bus_sel |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |

## Verification
The hardest situation to reach from the ports is a write that arrives while the transmit slot is full and a frame is already on the line. The slot is emptied one cycle after it is loaded whenever the shifter is idle, so the stimulus polls bit 9 the way software would. It writes a first byte, waits for ready, writes a second byte while the first is still shifting, and then writes a third byte, which must be dropped. The overrun case is reached by driving two complete frames without a consume between them. The bench then checks that the first byte is still held and that bit 12 is sticky until it is cleared.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
    localparam int BYTE_W      = 8;
    localparam int BUS_W       = 32;
    // word indices (byte offset >> 2)
    localparam int WIDX_DATA   = 0;
    localparam int WIDX_CTRL   = 1;
    localparam int WIDX_RATE   = 2;
    // data word fields
    localparam int DB_RXV      = 8;
    localparam int DB_TXR      = 9;
    // control word fields
    localparam int CB_MODE     = 2;
    localparam int CB_TXO      = 7;
    localparam int CB_RXO      = 8;
    localparam int CB_OVR      = 12;
    // rate word fields
    localparam int RB_SCALE    = 16;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK
    } rx_state_e;
endpackage

// File: rtl/serreg_rate.sv
module serreg_rate #(
    parameter int STEP_W  = 16,
    parameter int SCALE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STEP_W-1:0]  step,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    typedef struct packed {
        logic [SCALE_W-1:0] pre;
        logic [STEP_W-1:0]  acc;
    } rate_t;

    rate_t q, d;
    logic  strobe;
    logic [STEP_W:0] sum;

    always_comb begin
        d      = q;
        strobe = (q.pre >= scale);
        sum    = {1'b0, q.acc} + {1'b0, step};
        tick   = 1'b0;
        if (strobe) begin
            d.pre = '0;
            d.acc = sum[STEP_W-1:0];
            tick  = sum[STEP_W];
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/serreg_tx.sv
module serreg_tx import serreg_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              slot_v,
    input  logic [BYTE_W-1:0] slot_b,
    output logic              take,
    output logic              txd
);
    localparam int FRAME_W = BYTE_W + 2;
    localparam int TC_W    = $clog2(OVS);
    localparam int BC_W    = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [TC_W-1:0]    tcnt;
        logic [BC_W-1:0]    bcnt;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d    = q;
        take = !q.busy && slot_v;
        if (take) begin
            d.busy = 1'b1;
            d.sh   = {1'b1, slot_b, 1'b0};
            d.tcnt = '0;
            d.bcnt = '0;
        end else if (q.busy && tick) begin
            if (q.tcnt == TC_W'(OVS - 1)) begin
                d.tcnt = '0;
                d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                if (q.bcnt == BC_W'(FRAME_W - 1)) d.busy = 1'b0;
                else                              d.bcnt = q.bcnt + 1'b1;
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy <= 1'b0;
            q.sh   <= '1;
            q.tcnt <= '0;
            q.bcnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign txd = q.sh[0];

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> txd); // R2
endmodule

// File: rtl/serreg_rx.sv
module serreg_rx import serreg_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              done,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int TC_W = $clog2(OVS);
    localparam int BC_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         st;
        logic [TC_W-1:0]   tcnt;
        logic [BC_W-1:0]   bcnt;
        logic [BYTE_W-1:0] sh;
        logic              done;
    } rx_t;

    rx_t  q, d;
    logic line;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.sync = {q.sync[0], rxd};
        line   = q.sync[1];
        if (q.st == RX_BREAK) begin
            if (line) d.st = RX_IDLE;
        end else if (tick) begin
            case (q.st)
                RX_IDLE: if (!line) begin
                    d.st   = RX_START;
                    d.tcnt = '0;
                end
                RX_START: if (q.tcnt == TC_W'(OVS/2 - 1)) begin
                    d.tcnt = '0;
                    d.bcnt = '0;
                    d.st   = line ? RX_IDLE : RX_DATA;
                end else begin
                    d.tcnt = q.tcnt + 1'b1;
                end
                RX_DATA: if (q.tcnt == TC_W'(OVS - 1)) begin
                    d.tcnt = '0;
                    d.sh   = {line, q.sh[BYTE_W-1:1]};
                    if (q.bcnt == BC_W'(BYTE_W - 1)) d.st = RX_STOP;
                    else                             d.bcnt = q.bcnt + 1'b1;
                end else begin
                    d.tcnt = q.tcnt + 1'b1;
                end
                RX_STOP: if (q.tcnt == TC_W'(OVS - 1)) begin
                    d.tcnt = '0;
                    d.done = line;
                    d.st   = line ? RX_IDLE : RX_BREAK;
                end else begin
                    d.tcnt = q.tcnt + 1'b1;
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.st   <= RX_IDLE;
            q.tcnt <= '0;
            q.bcnt <= '0;
            q.sh   <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done   = q.done;
    assign byte_o = q.sh;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_BREAK_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_BREAK) |=> !done); // R10
endmodule

// File: rtl/serreg_top.sv
module serreg_top import serreg_pkg::*; #(
    parameter int OVS     = 16,
    parameter int STEP_W  = 16,
    parameter int SCALE_W = 12,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rxd,
    output logic              txd
);
    localparam int WI_W = ADDR_W - 2;

    typedef struct packed {
        logic               txh_v;
        logic [BYTE_W-1:0]  txh_b;
        logic               rxh_v;
        logic [BYTE_W-1:0]  rxh_b;
        logic [1:0]         mode;
        logic               txo;
        logic               rxo;
        logic               ovr;
        logic [STEP_W-1:0]  step;
        logic [SCALE_W-1:0] scale;
    } regs_t;

    regs_t q, d;

    logic [WI_W-1:0]   widx;
    logic              wr_data, wr_ctrl, wr_rate;
    logic              push, pop;
    logic              tick, tx_take, rx_done;
    logic [BYTE_W-1:0] rx_byte;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign wr_data = bus_sel && bus_wr && (widx == WI_W'(WIDX_DATA));
    assign wr_ctrl = bus_sel && bus_wr && (widx == WI_W'(WIDX_CTRL));
    assign wr_rate = bus_sel && bus_wr && (widx == WI_W'(WIDX_RATE));
    assign push    = wr_data && bus_wdata[DB_TXR] && !q.txh_v;
    assign pop     = wr_data && bus_wdata[DB_RXV];

    serreg_rate #(.STEP_W(STEP_W), .SCALE_W(SCALE_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (q.step),
        .scale (q.scale),
        .tick  (tick)
    );

    serreg_tx #(.OVS(OVS)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .slot_v (q.txh_v),
        .slot_b (q.txh_b),
        .take   (tx_take),
        .txd    (txd)
    );

    serreg_rx #(.OVS(OVS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .rxd    (rxd),
        .done   (rx_done),
        .byte_o (rx_byte)
    );

    always_comb begin
        d = q;
        // transmit slot: emptied by the shifter, filled by a bus push
        if (tx_take) d.txh_v = 1'b0;
        if (push) begin
            d.txh_v = 1'b1;
            d.txh_b = bus_wdata[BYTE_W-1:0];
        end
        // control word; W1C of the overrun flag precedes a new overrun
        if (wr_ctrl) begin
            d.mode = bus_wdata[CB_MODE +: 2];
            d.txo  = bus_wdata[CB_TXO];
            d.rxo  = bus_wdata[CB_RXO];
            if (bus_wdata[CB_OVR]) d.ovr = 1'b0;
        end
        // receive slot: a consume in the same cycle frees it first
        if (pop) d.rxh_v = 1'b0;
        if (rx_done) begin
            if (q.rxh_v && !pop) begin
                d.ovr = 1'b1;
            end else begin
                d.rxh_v = 1'b1;
                d.rxh_b = rx_byte;
            end
        end
        if (wr_rate) begin
            d.step  = bus_wdata[STEP_W-1:0];
            d.scale = bus_wdata[RB_SCALE +: SCALE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (widx == WI_W'(WIDX_DATA)) begin
            bus_rdata[BYTE_W-1:0] = q.rxh_b;
            bus_rdata[DB_RXV]     = q.rxh_v;
            bus_rdata[DB_TXR]     = !q.txh_v;
        end else if (widx == WI_W'(WIDX_CTRL)) begin
            bus_rdata[CB_MODE +: 2] = q.mode;
            bus_rdata[CB_TXO]       = q.txo;
            bus_rdata[CB_RXO]       = q.rxo;
            bus_rdata[CB_OVR]       = q.ovr;
        end else if (widx == WI_W'(WIDX_RATE)) begin
            bus_rdata[STEP_W-1:0]          = q.step;
            bus_rdata[RB_SCALE +: SCALE_W] = q.scale;
        end
    end

    AST_TX_SLOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && bus_wdata[DB_TXR] && !q.txh_v) |=> q.txh_v); // R2
    AST_TX_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && bus_wdata[DB_TXR] && q.txh_v && !tx_take) |=> (q.txh_v && $stable(q.txh_b))); // R3
    AST_RX_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && bus_wdata[DB_RXV] && !rx_done) |=> !q.rxh_v); // R5
    AST_OVR_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && q.rxh_v && !pop) |=> (q.rxh_v && q.ovr && $stable(q.rxh_b))); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovr && !(wr_ctrl && bus_wdata[CB_OVR])) |=> q.ovr); // R7
endmodule

// File: tb/tb_serreg_top.sv
module tb_serreg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    localparam logic [7:0] VEC [0:5] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C};

    serreg_top dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_ready();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(4'h0, v);
            if (v[9]) break;
            @(negedge clk);
        end
    endtask

    // capture one frame from txd; seen=0 if no start edge within 12 bits
    task automatic tx_cap(input int bc, output logic [7:0] b, output logic stp, output logic seen);
        seen = 1; b = '0; stp = 0;
        for (int i = 0; i < bc * 12 && txd; i++) @(negedge clk);
        if (txd) begin seen = 0; return; end
        repeat (bc / 2) @(negedge clk);
        if (txd) seen = 0;
        for (int k = 0; k < 8; k++) begin
            repeat (bc) @(negedge clk);
            b[k] = txd;
        end
        repeat (bc) @(negedge clk);
        stp = txd;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic stopv, input int bc);
        @(negedge clk);
        rxd = 0;
        repeat (bc) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = b[k];
            repeat (bc) @(negedge clk);
        end
        rxd = stopv;
        repeat (bc) @(negedge clk);
        rxd = 1;
        repeat (bc) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        logic        stp, seen;

        repeat (3) @(negedge clk);
        // R1: reset state
        rd(4'h0, v); chk("R1 data", v, 32'h200);
        rd(4'h4, v); chk("R1 ctrl", v, 32'h0);
        rd(4'h8, v); chk("R1 rate", v, 32'h0);
        chk("R1 txd", {31'b0, txd}, 32'h1);
        rst_n = 1;
        @(negedge clk);

        // R8: control bits
        wr(4'h4, 32'hFFFF_EFFF); rd(4'h4, v); chk("R8 ctrl keep", v, 32'h18C);
        wr(4'h4, 32'h0000_0084); rd(4'h4, v); chk("R8 ctrl rewrite", v, 32'h84);
        // R9: rate word, 64 cycles per bit
        wr(4'h8, 32'h0001_8000); rd(4'h8, v); chk("R9 rate", v, 32'h0001_8000);

        // vector table: transmit, receive, consume
        for (int i = 0; i < 6; i++) begin
            wait_ready();
            wr(4'h0, 32'h200 | 32'(VEC[i]));
            tx_cap(64, b, stp, seen);
            chk("R2 tx seen", {31'b0, seen}, 32'h1);
            chk("R2 tx byte", {24'b0, b}, {24'b0, VEC[i]});
            chk("R2 tx stop", {31'b0, stp}, 32'h1);
            rx_send(VEC[i], 1'b1, 64);
            rd(4'h0, v); chk("R4 rx byte", v & 32'h3FF, 32'h300 | 32'(VEC[i]));
            wr(4'h0, 32'h100);
            rd(4'h0, v); chk("R5 consume", v & 32'h300, 32'h200);
        end

        // R3: full slot while a frame is shifting, extra write dropped
        wait_ready();
        wr(4'h0, 32'h2C1);
        wait_ready();
        wr(4'h0, 32'h2D2);
        rd(4'h0, v); chk("R3 not ready", v & 32'h200, 32'h0);
        wr(4'h0, 32'h2E3);
        tx_cap(64, b, stp, seen); chk("R3 first", {24'b0, b}, 32'hC1);
        tx_cap(64, b, stp, seen); chk("R3 second", {24'b0, b}, 32'hD2);
        tx_cap(64, b, stp, seen); chk("R3 third dropped", {31'b0, seen}, 32'h0);

        // R5: write with both flags clear has no effect
        rx_send(8'h6B, 1'b1, 64);
        wr(4'h0, 32'h0000_0055);
        rd(4'h0, v); chk("R5 no-op", v & 32'h3FF, 32'h36B);
        tx_cap(64, b, stp, seen); chk("R5 no-op line", {31'b0, seen}, 32'h0);

        // R6: both flags set queue and consume at once
        wr(4'h0, 32'h35A);
        rd(4'h0, v); chk("R6 consumed", v & 32'h100, 32'h0);
        tx_cap(64, b, stp, seen); chk("R6 sent", {24'b0, b}, 32'h5A);

        // R7: overrun keeps the old byte and sets a sticky flag
        rx_send(8'h11, 1'b1, 64);
        rx_send(8'h22, 1'b1, 64);
        rd(4'h0, v); chk("R7 old kept", v & 32'h1FF, 32'h111);
        rd(4'h4, v); chk("R7 ovr set", v, 32'h1084);
        wr(4'h0, 32'h100);
        rd(4'h4, v); chk("R7 ovr sticky", v, 32'h1084);
        wr(4'h4, 32'h1084);
        rd(4'h4, v); chk("R7 ovr cleared", v, 32'h84);

        // R10: low stop bit discards the frame
        rx_send(8'h47, 1'b0, 64);
        repeat (200) @(negedge clk);
        rd(4'h0, v); chk("R10 discarded", v & 32'h100, 32'h0);
        rx_send(8'h48, 1'b1, 64);
        rd(4'h0, v); chk("R10 recovers", v & 32'h1FF, 32'h148);
        wr(4'h0, 32'h100);

        // R11: unused offset
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, v); chk("R11 read zero", v, 32'h0);
        rd(4'h4, v); chk("R11 ctrl kept", v, 32'h84);
        rd(4'h8, v); chk("R11 rate kept", v, 32'h0001_8000);
        rd(4'h0, v); chk("R11 data kept", v & 32'h300, 32'h200);

        // R9: faster rate, 32 cycles per bit
        wr(4'h8, 32'h0000_8000);
        wait_ready();
        wr(4'h0, 32'h2A6);
        tx_cap(32, b, stp, seen);
        chk("R9 fast byte", {24'b0, b}, 32'hA6);
        chk("R9 fast stop", {31'b0, stp}, 32'h1);
        rx_send(8'h9D, 1'b1, 32);
        rd(4'h0, v); chk("R9 fast rx", v & 32'h1FF, 32'h19D);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule